// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block places narrow data between a 32-bit execution datapath and a 32-bit memory data bus. On the store side it takes a byte or halfword from the bottom of the datapath operand and moves it onto the memory lane that the two low address bits select. It also produces the matching byte write enables. On the load side it picks the addressed byte or halfword out of the memory word and returns it right-justified. It is zero-extended or sign-extended to the full width, depending on a control input.

A separate result path shifts an operand by a fixed step of 1, 2 or 4 bit positions. Left shifts fill with zeros. Right shifts either fill with zeros or rotate the bits that fall off the bottom back in at the top.

All three result groups are registered. A set of inputs applied before a rising clock edge appears on the outputs just after that edge. The block has no state beyond this output register.

Top module: `lane_aligner`

## Requirements
- R1: While rst_n is low, every output is zero: mem_wdata, mem_be, misaligned, ld_result and sh_result.
- R2: With acc_size=00 (byte), st_data[7:0] appears on lane k = addr_lo, at bits 8k+7:8k; offset 3 uses bits 31:24. The other lanes of mem_wdata are zero, and mem_be has only bit k set.
- R3: With acc_size=01 (halfword) and addr_lo[0]=0, st_data[15:0] appears on bits 15:0 with mem_be=0011 when addr_lo[1]=0. It appears on bits 31:16 with mem_be=1100 when addr_lo[1]=1. The remaining bits of mem_wdata are zero.
- R4: With acc_size=10 or 11 (word), mem_wdata equals st_data and mem_be=1111, whatever the value of addr_lo.
- R5: A halfword access with addr_lo[0]=1 sets misaligned, forces mem_be=0000, mem_wdata=0 and ld_result=0. For every other access, misaligned is 0.
- R6: A byte load returns lane addr_lo of ld_data in bits 7:0. Bits 31:8 are zero when sign_ext=0 and copies of the byte's bit 7 when sign_ext=1.
- R7: An aligned halfword load returns bits 15:0 (addr_lo[1]=0) or bits 31:16 (addr_lo[1]=1) of ld_data in bits 15:0. Bits 31:16 are zero when sign_ext=0 and copies of the halfword's bit 15 when sign_ext=1.
- R8: A word load returns ld_data unchanged; sign_ext and addr_lo have no effect.
- R9: With sh_dir=0 (left), sh_result is sh_in shifted left by 1, 2 or 4 for sh_amt codes 00, 01 and 10, with zeros entering at bit 0; sh_rot has no effect.
- R10: With sh_dir=1 (right) and sh_rot=0, sh_result is sh_in shifted right by the coded step, with zeros entering at bit 31.
- R11: With sh_dir=1 and sh_rot=1, sh_result is sh_in rotated right by the coded step, so bits leaving bit 0 re-enter at bit 31.
- R12: sh_amt=11 passes sh_in to sh_result unchanged in every direction and mode.
- R13: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| sign_ext | input | 1 | 1 sign-extends narrow loads, 0 zero-extends |
| addr_lo | input | 2 | Low address bits choosing the byte lane |
| st_data | input | 32 | Store operand, narrow data in the low bits |
| ld_data | input | 32 | Word read from the memory bus |
| sh_in | input | 32 | Shift path operand |
| sh_dir | input | 1 | 0 left, 1 right |
| sh_rot | input | 1 | 1 rotates on right shifts |
| sh_amt | input | 2 | Step code: 00 one, 01 two, 10 four, 11 none |
| mem_wdata | output | 32 | Store data placed on the bus lanes |
| mem_be | output | 4 | Byte write enables, bit k for lane k |
| misaligned | output | 1 | Halfword access at an odd address |
| ld_result | output | 32 | Extended load result |
| sh_result | output | 32 | Shift path result |

## Verification
The hardest cases to reach are those where extension and lane choice interact. A sign bit must come from the selected lane and not from a neighbour. The stimulus therefore uses load words in which each lane has a different top bit: one lane is negative while the lane beside it is positive. Each offset is then read with both extension settings. Rotation is checked with operands whose low bits differ from their high bits, so that a logical shift and a rotate give visibly different results for every step size. The odd halfword address is applied to both loads and stores, and it is followed directly by an aligned access to show that the flag clears.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        STEP_ONE  = 2'b00,
        STEP_TWO  = 2'b01,
        STEP_FOUR = 2'b10,
        STEP_NONE = 2'b11
    } step_e;

    function automatic logic is_word(input acc_size_e s);
        return (s == SZ_WORD) || (s == SZ_WORD2);
    endfunction

endpackage

// File: rtl/la_store_lane.sv
module la_store_lane
    import la_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int AW    = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] st_data,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic              misal
);

    localparam int HW = AW - 1;

    assign misal = (size == SZ_HALF) && addr[0];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic       hit;
        logic [7:0] src;

        always_comb begin
            unique case (size)
                SZ_BYTE: hit = (addr == AW'(k));
                SZ_HALF: hit = !addr[0] && (addr[AW-1:1] == HW'(k / 2));
                default: hit = 1'b1;
            endcase
        end

        always_comb begin
            unique case (size)
                SZ_BYTE: src = st_data[7:0];
                SZ_HALF: src = st_data[8*(k%2) +: 8];
                default: src = st_data[8*k +: 8];
            endcase
        end

        assign be[k]          = hit;
        assign wdata[8*k +: 8] = hit ? src : 8'h00;
    end

endmodule

// File: rtl/la_load_extract.sv
module la_load_extract
    import la_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int AW    = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic [AW-1:0]     addr,
    input  logic              sign_ext,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] result
);

    logic [7:0]  byte_v;
    logic [15:0] half_v;

    assign byte_v = ld_data[{addr, 3'b000} +: 8];
    assign half_v = ld_data[{addr[AW-1:1], 4'b0000} +: 16];

    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){sign_ext & byte_v[7]}}, byte_v};
            SZ_HALF: begin
                if (addr[0]) begin
                    result = '0;
                end else begin
                    result = {{(DATA_W-16){sign_ext & half_v[15]}}, half_v};
                end
            end
            default: result = ld_data;
        endcase
    end

endmodule

// File: rtl/la_shifter.sv
module la_shifter
    import la_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic              dir_right,
    input  logic              rotate,
    input  step_e             step,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] left_v;
    logic [DATA_W-1:0] right_v;
    logic [DATA_W-1:0] rot_v;

    always_comb begin
        unique case (step)
            STEP_ONE: begin
                left_v  = {din[DATA_W-2:0], 1'b0};
                right_v = {1'b0, din[DATA_W-1:1]};
                rot_v   = {din[0], din[DATA_W-1:1]};
            end
            STEP_TWO: begin
                left_v  = {din[DATA_W-3:0], 2'b00};
                right_v = {2'b00, din[DATA_W-1:2]};
                rot_v   = {din[1:0], din[DATA_W-1:2]};
            end
            STEP_FOUR: begin
                left_v  = {din[DATA_W-5:0], 4'h0};
                right_v = {4'h0, din[DATA_W-1:4]};
                rot_v   = {din[3:0], din[DATA_W-1:4]};
            end
            STEP_NONE: begin
                left_v  = din;
                right_v = din;
                rot_v   = din;
            end
        endcase
    end

    always_comb begin
        if (!dir_right) begin
            dout = left_v;
        end else if (rotate) begin
            dout = rot_v;
        end else begin
            dout = right_v;
        end
    end

endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
    import la_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [1:0]                      acc_size,
    input  logic                            sign_ext,
    input  logic [$clog2(DATA_W/8)-1:0]     addr_lo,
    input  logic [DATA_W-1:0]               st_data,
    input  logic [DATA_W-1:0]               ld_data,
    input  logic [DATA_W-1:0]               sh_in,
    input  logic                            sh_dir,
    input  logic                            sh_rot,
    input  logic [1:0]                      sh_amt,
    output logic [DATA_W-1:0]               mem_wdata,
    output logic [DATA_W/8-1:0]             mem_be,
    output logic                            misaligned,
    output logic [DATA_W-1:0]               ld_result,
    output logic [DATA_W-1:0]               sh_result
);

    localparam int LANES = DATA_W / 8;

    acc_size_e         sz;
    step_e             stp;
    logic [DATA_W-1:0] wdata_d;
    logic [LANES-1:0]  be_d;
    logic              misal_d;
    logic [DATA_W-1:0] ld_d;
    logic [DATA_W-1:0] sh_d;

    assign sz  = acc_size_e'(acc_size);
    assign stp = step_e'(sh_amt);

    la_store_lane #(.DATA_W(DATA_W)) u_store (
        .size    (sz),
        .addr    (addr_lo),
        .st_data (st_data),
        .wdata   (wdata_d),
        .be      (be_d),
        .misal   (misal_d)
    );

    la_load_extract #(.DATA_W(DATA_W)) u_load (
        .size     (sz),
        .addr     (addr_lo),
        .sign_ext (sign_ext),
        .ld_data  (ld_data),
        .result   (ld_d)
    );

    la_shifter #(.DATA_W(DATA_W)) u_shift (
        .din       (sh_in),
        .dir_right (sh_dir),
        .rotate    (sh_rot),
        .step      (stp),
        .dout      (sh_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_wdata  <= '0;
            mem_be     <= '0;
            misaligned <= 1'b0;
            ld_result  <= '0;
            sh_result  <= '0;
        end else begin
            mem_wdata  <= wdata_d;
            mem_be     <= be_d;
            misaligned <= misal_d;
            ld_result  <= ld_d;
            sh_result  <= sh_d;
        end
    end

    // R2
    byte_one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b00) |=> ($countones(mem_be) == 1));

    // R3
    half_two_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b01 && !addr_lo[0]) |=> ($countones(mem_be) == 2 && !misaligned));

    // R4
    word_all_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_size[1] |=> (mem_be == '1 && mem_wdata == $past(st_data)));

    // R5
    misaligned_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b01 && addr_lo[0]) |=> (misaligned && mem_be == '0 && ld_result == '0));

    // R6
    byte_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b00 && !sign_ext) |=> (ld_result[DATA_W-1:8] == '0));

    // R9
    left_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_dir && sh_amt != 2'b11) |=> !sh_result[0]);

    // R11
    rotate_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_dir && sh_rot) |=> ($countones(sh_result) == $countones($past(sh_in))));

    // R13
    word_load_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_size[1] |=> (ld_result == $past(ld_data)));

endmodule

// File: tb/sim_lane_aligner.sv
module sim_lane_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic        sign_ext = 1'b0;
    logic [1:0]  addr_lo = 2'b00;
    logic [31:0] st_data = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] sh_in = '0;
    logic        sh_dir = 1'b0;
    logic        sh_rot = 1'b0;
    logic [1:0]  sh_amt = 2'b00;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        misaligned;
    logic [31:0] ld_result;
    logic [31:0] sh_result;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    lane_aligner u0 (
        .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .sign_ext(sign_ext),
        .addr_lo(addr_lo), .st_data(st_data), .ld_data(ld_data), .sh_in(sh_in),
        .sh_dir(sh_dir), .sh_rot(sh_rot), .sh_amt(sh_amt),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .misaligned(misaligned),
        .ld_result(ld_result), .sh_result(sh_result)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock step: inputs set at negedge, results read at following negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int step_of(input logic [1:0] code);
        case (code)
            2'b00: return 1;
            2'b01: return 2;
            2'b10: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] ref_shift(input logic [31:0] x, input logic right,
                                              input logic rot, input int n);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            if (!right) r[i] = (i >= n) ? x[i-n] : 1'b0;
            else if (rot) r[i] = x[(i+n)%32];
            else r[i] = (i + n < 32) ? x[i+n] : 1'b0;
        end
        return r;
    endfunction

    task automatic t_reset();
        check("R1 wdata", mem_wdata, 32'h0);
        check("R1 be", {28'h0, mem_be}, 32'h0);
        check("R1 misaligned", {31'h0, misaligned}, 32'h0);
        check("R1 ld_result", ld_result, 32'h0);
        check("R1 sh_result", sh_result, 32'h0);
    endtask

    task automatic t_byte_store();
        for (int k = 0; k < 4; k++) begin
            logic [31:0] ew;
            acc_size = 2'b00; addr_lo = 2'(k); st_data = 32'hDEAD_BEA5;
            step();
            ew = '0;
            for (int j = 0; j < 8; j++) ew[8*k+j] = st_data[j];
            check("R2 byte wdata", mem_wdata, ew);
            check("R2 byte be", {28'h0, mem_be}, 32'(1 << k));
            check("R5 no flag on byte", {31'h0, misaligned}, 32'h0);
        end
    endtask

    task automatic t_half_store();
        acc_size = 2'b01; addr_lo = 2'b00; st_data = 32'h1234_ABCD;
        step();
        check("R3 half low wdata", mem_wdata, 32'h0000_ABCD);
        check("R3 half low be", {28'h0, mem_be}, 32'h3);
        addr_lo = 2'b10;
        step();
        check("R3 half high wdata", mem_wdata, 32'hABCD_0000);
        check("R3 half high be", {28'h0, mem_be}, 32'hC);
    endtask

    task automatic t_word_store();
        for (int a = 0; a < 4; a++) begin
            acc_size = (a % 2 == 0) ? 2'b10 : 2'b11; addr_lo = 2'(a); st_data = 32'h8765_4321 + 32'(a);
            step();
            check("R4 word wdata", mem_wdata, 32'h8765_4321 + 32'(a));
            check("R4 word be", {28'h0, mem_be}, 32'hF);
        end
    endtask

    task automatic t_misaligned();
        acc_size = 2'b01; st_data = 32'hFFFF_FFFF; ld_data = 32'hFFFF_FFFF; sign_ext = 1'b1;
        for (int a = 1; a < 4; a += 2) begin
            addr_lo = 2'(a);
            step();
            check("R5 flag", {31'h0, misaligned}, 32'h1);
            check("R5 be", {28'h0, mem_be}, 32'h0);
            check("R5 wdata", mem_wdata, 32'h0);
            check("R5 ld_result", ld_result, 32'h0);
        end
        addr_lo = 2'b10;
        step();
        check("R5 flag clears", {31'h0, misaligned}, 32'h0);
    endtask

    task automatic t_byte_load();
        ld_data = 32'h7F80_01FE;
        acc_size = 2'b00;
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 2; s++) begin
                logic [7:0]  b;
                logic [31:0] e;
                addr_lo = 2'(k); sign_ext = s[0];
                step();
                b = ld_data[8*k +: 8];
                e = {24'h0, b};
                if (s == 1 && b[7]) e[31:8] = 24'hFF_FFFF;
                check("R6 byte load", ld_result, e);
            end
        end
    endtask

    task automatic t_half_load();
        ld_data = 32'h7FFF_8001;
        acc_size = 2'b01;
        addr_lo = 2'b00; sign_ext = 1'b1;
        step();
        check("R7 half low signed", ld_result, 32'hFFFF_8001);
        sign_ext = 1'b0;
        step();
        check("R7 half low unsigned", ld_result, 32'h0000_8001);
        addr_lo = 2'b10; sign_ext = 1'b1;
        step();
        check("R7 half high signed", ld_result, 32'h0000_7FFF);
        ld_data = 32'hC000_1234;
        step();
        check("R7 half high negative", ld_result, 32'hFFFF_C000);
    endtask

    task automatic t_word_load();
        ld_data = 32'h8000_00FF; acc_size = 2'b10; sign_ext = 1'b1; addr_lo = 2'b11;
        step();
        check("R8 word load", ld_result, 32'h8000_00FF);
        sign_ext = 1'b0; addr_lo = 2'b01;
        step();
        check("R8 word load ignores ext", ld_result, 32'h8000_00FF);
    endtask

    task automatic t_shifts();
        logic [31:0] pats [3];
        pats[0] = 32'h8000_000F;
        pats[1] = 32'hA5A5_3C3C;
        pats[2] = 32'h0000_0001;
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 4; c++) begin
                for (int m = 0; m < 4; m++) begin
                    sh_in = pats[p]; sh_amt = 2'(c); sh_dir = m[1]; sh_rot = m[0];
                    step();
                    if (c == 3) check("R12 no step", sh_result, pats[p]);
                    else if (!sh_dir) check("R9 left", sh_result, ref_shift(pats[p], 1'b0, 1'b0, step_of(2'(c))));
                    else if (!sh_rot) check("R10 right logical", sh_result, ref_shift(pats[p], 1'b1, 1'b0, step_of(2'(c))));
                    else check("R11 rotate right", sh_result, ref_shift(pats[p], 1'b1, 1'b1, step_of(2'(c))));
                end
            end
        end
    endtask

    task automatic t_latency();
        acc_size = 2'b10; ld_data = 32'h1111_1111;
        step();
        ld_data = 32'h2222_2222;
        @(posedge clk);
        #5;
        check("R13 holds before edge", ld_result, 32'h2222_2222);
        @(negedge clk);
        ld_data = 32'h3333_3333;
        #5;
        check("R13 no change mid-cycle", ld_result, 32'h2222_2222);
        @(posedge clk);
        @(negedge clk);
        check("R13 updates after edge", ld_result, 32'h3333_3333);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        acc_size = 2'b00;
        st_data  = 32'hFFFF_FFFF;
        ld_data  = 32'hFFFF_FFFF;
        sh_in    = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_byte_store();
        t_half_store();
        t_word_store();
        t_misaligned();
        t_byte_load();
        t_half_load();
        t_word_load();
        t_shifts();
        t_latency();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule